// File: doc/BRIEF.md
# Tagged Point-to-Point Stream FIFO Link

This block is a one-way channel between exactly one producer and one consumer on a single clock. Nothing is arbitrated or shared. Each entry holds a data word, 32 bits by default, and one tag bit. The tag marks the entry as a control word (1) or a plain data word (0). The tag travels with its word and comes out unchanged. Entries leave in the order they entered. The head entry is shown on the read outputs without any wait, and a read strobe removes it.

Every attempt on either side is either blocking or non-blocking:

- **Blocking.** If the attempt cannot complete this cycle, the block raises a stall indication. The caller holds its request until the stall clears.
- **Non-blocking.** If the attempt cannot complete this cycle, it fails at once and reports the failure in the same cycle.

Two extra behaviours apply to non-blocking attempts:

- A non-blocking write that hits a full FIFO is dropped. One cycle later, a single-cycle overflow pulse follows.
- A non-blocking read compares the head entry's tag with the tag the caller expected. A mismatch raises an error flag, and the entry is consumed anyway.

Top module: `tagged_stream_link`

## Requirements
- R1: Words are delivered on rd_data in exactly the order they were accepted on the write side.
- R2: The tag bit given with a word on wr_ctrl (1 = control, 0 = data) appears on rd_ctrl together with that same word.
- R3: wr_full is high exactly when DEPTH entries are stored. A write attempt while full stores nothing, and fill_level stays at DEPTH.
- R4: rd_exists is high exactly when at least one entry is stored. A read attempt while empty removes nothing and leaves rd_exists low.
- R5: A blocking write (wr_nonblock = 0) while full raises wr_stall in that cycle, with wr_done and wr_fail low. A write while not full raises wr_done.
- R6: A non-blocking write (wr_nonblock = 1) while full raises wr_fail in that cycle. The word is dropped, and wr_overflow is high for exactly the next cycle.
- R7: A blocking read while empty raises rd_stall with rd_done low. A non-blocking read while empty raises rd_fail with rd_done low.
- R8: When a read and a write both complete in the same cycle on a FIFO that is neither empty nor full, fill_level is unchanged.
- R9: A non-blocking read whose head tag differs from rd_expect_ctrl raises rd_tag_err in that cycle, and the entry is still removed. Blocking reads never raise rd_tag_err.
- R10: While rst_n is low at a clock edge the FIFO is emptied: fill_level becomes 0, rd_exists and wr_full go low, and wr_overflow clears.
- R11: fill_level rises by one after a cycle with only a completed write, and falls by one after a cycle with only a completed read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write attempt strobe |
| wr_nonblock | input | 1 | 1 = non-blocking write attempt |
| wr_data | input | DATA_W | Word to write |
| wr_ctrl | input | 1 | Tag of word: 1 control, 0 data |
| wr_full | output | 1 | FIFO holds DEPTH entries |
| wr_done | output | 1 | Write accepted this cycle |
| wr_stall | output | 1 | Blocking write must be held |
| wr_fail | output | 1 | Non-blocking write rejected |
| wr_overflow | output | 1 | One-cycle pulse after a dropped write |
| rd_req | input | 1 | Read attempt strobe |
| rd_nonblock | input | 1 | 1 = non-blocking read attempt |
| rd_expect_ctrl | input | 1 | Tag the non-blocking reader expects |
| rd_data | output | DATA_W | Head word |
| rd_ctrl | output | 1 | Tag of head word |
| rd_exists | output | 1 | At least one entry stored |
| rd_done | output | 1 | Head entry removed this cycle |
| rd_stall | output | 1 | Blocking read must be held |
| rd_fail | output | 1 | Non-blocking read on empty FIFO |
| rd_tag_err | output | 1 | Non-blocking read tag mismatch |
| fill_level | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The assertions check on every cycle that storage never takes a push while full or a pop while empty. They also check the following every cycle:

- fill_level moves by exactly one, or stays put, as the completed operations dictate.
- A stalled blocking write never pushes.
- A rejected non-blocking write is followed by an overflow pulse.
- A tag error always comes with a pop.
- Reset leaves the store empty.

Only the bench scenarios can show end-to-end properties against a queue model:

- Word order and tag pairing survive a full fill and drain.
- A dropped word never reappears.
- Words keep their order through a run of simultaneous reads and writes.

// File: rtl/tsl_pkg.sv
// Shared types for the tagged stream link.
// Assumes: a single clock domain; the outcome of each attempt is decided in the cycle it is made.
package tsl_pkg;
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_DONE  = 2'd1,
        XF_STALL = 2'd2,
        XF_FAIL  = 2'd3
    } xfer_e;
endpackage

// File: rtl/tsl_store.sv
// Circular storage for tagged words, with head and tail pointers and an occupancy count.
// Assumes: the caller never pushes while full and never pops while empty.
// Each entry is {tag, data}; the head entry is visible without latency.
module tsl_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DATA_W:0]            push_word,
    output logic [DATA_W:0]            head_word,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DATA_W:0] mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;

    // Pointer advance: natural wrap for power-of-two depths, explicit wrap otherwise.
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_mod
            assign wr_nxt = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign head_word = mem[rd_ptr];

    // Entry write: stores the tagged word at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_word;
    end

    // Pointer and count update; reset empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) !(push && full));
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) !(pop && empty));
    a_r8_balanced: assert property (@(posedge clk) disable iff (!rst_n) (push && pop) |=> $stable(count));
    a_r11_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == CW'($past(count) + 1'b1)));
    a_r11_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count == CW'($past(count) - 1'b1)));
    a_r10_reset_empty: assert property (@(posedge clk) (rst_n === 1'b0) |=> (count == '0));
endmodule

// File: rtl/tsl_wr_side.sv
// Write-side attempt logic: accepts, stalls or fails each write, and pulses overflow after a drop.
// Assumes: full comes from storage and reflects the current cycle.
module tsl_wr_side
    import tsl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  logic  nonblock,
    input  logic  full,
    output xfer_e status,
    output logic  push,
    output logic  overflow
);
    // Attempt outcome for this cycle.
    always_comb begin
        if (!req)          status = XF_IDLE;
        else if (!full)    status = XF_DONE;
        else if (nonblock) status = XF_FAIL;
        else               status = XF_STALL;
    end

    assign push = (status == XF_DONE);

    // Overflow pulse: one cycle after a dropped non-blocking write.
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else        overflow <= (status == XF_FAIL);
    end

    a_r5_stall_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (req && full && !nonblock) |-> !push);
    a_r6_drop_then_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req && full && nonblock) |=> overflow);
endmodule

// File: rtl/tsl_rd_side.sv
// Read-side attempt logic: pops, stalls or fails each read, and checks the head tag on non-blocking reads.
// Assumes: empty and head_ctrl come from storage and reflect the current cycle.
module tsl_rd_side
    import tsl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  logic  nonblock,
    input  logic  expect_ctrl,
    input  logic  empty,
    input  logic  head_ctrl,
    output xfer_e status,
    output logic  pop,
    output logic  tag_err
);
    // Attempt outcome for this cycle.
    always_comb begin
        if (!req)          status = XF_IDLE;
        else if (!empty)   status = XF_DONE;
        else if (nonblock) status = XF_FAIL;
        else               status = XF_STALL;
    end

    assign pop     = (status == XF_DONE);
    assign tag_err = pop && nonblock && (head_ctrl != expect_ctrl);

    a_r9_err_consumes: assert property (@(posedge clk) disable iff (!rst_n) tag_err |-> (req && !empty));
    a_r7_empty_no_pop: assert property (@(posedge clk) disable iff (!rst_n) (req && empty) |-> !pop);
endmodule

// File: rtl/tagged_stream_link.sv
// Top of the tagged stream link: storage plus one attempt unit per side.
// Assumes: one writer and one reader on the same clock; synchronous active-low reset.
module tagged_stream_link
    import tsl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req,
    input  logic                       wr_nonblock,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       wr_ctrl,
    output logic                       wr_full,
    output logic                       wr_done,
    output logic                       wr_stall,
    output logic                       wr_fail,
    output logic                       wr_overflow,
    input  logic                       rd_req,
    input  logic                       rd_nonblock,
    input  logic                       rd_expect_ctrl,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_ctrl,
    output logic                       rd_exists,
    output logic                       rd_done,
    output logic                       rd_stall,
    output logic                       rd_fail,
    output logic                       rd_tag_err,
    output logic [$clog2(DEPTH+1)-1:0] fill_level
);
    xfer_e           wr_status, rd_status;
    logic            push, pop, full, empty;
    logic [DATA_W:0] head_word;

    tsl_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_word({wr_ctrl, wr_data}), .head_word(head_word),
        .count(fill_level), .full(full), .empty(empty)
    );

    tsl_wr_side u_wr (
        .clk(clk), .rst_n(rst_n), .req(wr_req), .nonblock(wr_nonblock),
        .full(full), .status(wr_status), .push(push), .overflow(wr_overflow)
    );

    tsl_rd_side u_rd (
        .clk(clk), .rst_n(rst_n), .req(rd_req), .nonblock(rd_nonblock),
        .expect_ctrl(rd_expect_ctrl), .empty(empty), .head_ctrl(head_word[DATA_W]),
        .status(rd_status), .pop(pop), .tag_err(rd_tag_err)
    );

    // Port decode of attempt outcomes and head entry.
    always_comb begin
        wr_full   = full;
        wr_done   = (wr_status == XF_DONE);
        wr_stall  = (wr_status == XF_STALL);
        wr_fail   = (wr_status == XF_FAIL);
        rd_exists = !empty;
        rd_done   = (rd_status == XF_DONE);
        rd_stall  = (rd_status == XF_STALL);
        rd_fail   = (rd_status == XF_FAIL);
        rd_data   = head_word[DATA_W-1:0];
        rd_ctrl   = head_word[DATA_W];
    end

    a_r4_exists_vs_full: assert property (@(posedge clk) disable iff (!rst_n) wr_full |-> rd_exists);
    a_r6_fail_only_when_full: assert property (@(posedge clk) disable iff (!rst_n) wr_fail |-> wr_full);
endmodule

// File: tb/tagged_stream_link_tb.sv
`timescale 1ns/1ps
module tagged_stream_link_tb;
    localparam int DW  = 32;
    localparam int DEP = 16;
    localparam int CW  = $clog2(DEP+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 0, wr_nonblock = 0, wr_ctrl = 0;
    logic [DW-1:0] wr_data = '0;
    logic rd_req = 0, rd_nonblock = 0, rd_expect_ctrl = 0;
    logic wr_full, wr_done, wr_stall, wr_fail, wr_overflow;
    logic [DW-1:0] rd_data;
    logic rd_ctrl, rd_exists, rd_done, rd_stall, rd_fail, rd_tag_err;
    logic [CW-1:0] fill_level;

    int errors = 0;
    int checks = 0;
    logic [DW:0] q[$];
    logic ovf_exp = 1'b0;

    always #2 clk = ~clk;

    tagged_stream_link #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_nonblock(wr_nonblock),
        .wr_data(wr_data), .wr_ctrl(wr_ctrl), .wr_full(wr_full), .wr_done(wr_done),
        .wr_stall(wr_stall), .wr_fail(wr_fail), .wr_overflow(wr_overflow),
        .rd_req(rd_req), .rd_nonblock(rd_nonblock), .rd_expect_ctrl(rd_expect_ctrl),
        .rd_data(rd_data), .rd_ctrl(rd_ctrl), .rd_exists(rd_exists), .rd_done(rd_done),
        .rd_stall(rd_stall), .rd_fail(rd_fail), .rd_tag_err(rd_tag_err),
        .fill_level(fill_level)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle of attempts; entered and left just after a falling edge.
    task automatic step(input logic wq, input logic [DW-1:0] wd, input logic wc, input logic wnb,
                        input logic rq, input logic rnb, input logic rexp);
        bit full_e, empty_e, wdone, rdone;
        wr_req = wq; wr_data = wd; wr_ctrl = wc; wr_nonblock = wnb;
        rd_req = rq; rd_nonblock = rnb; rd_expect_ctrl = rexp;
        #1;
        full_e  = (q.size() == DEP);
        empty_e = (q.size() == 0);
        wdone   = wq && !full_e;
        rdone   = rq && !empty_e;
        check("R3", "wr_full", 64'(wr_full), 64'(full_e));
        check("R4", "rd_exists", 64'(rd_exists), 64'(!empty_e));
        check("R5", "wr_done", 64'(wr_done), 64'(wdone));
        check("R5", "wr_stall", 64'(wr_stall), 64'(wq && full_e && !wnb));
        check("R6", "wr_fail", 64'(wr_fail), 64'(wq && full_e && wnb));
        check("R7", "rd_done", 64'(rd_done), 64'(rdone));
        check("R7", "rd_stall", 64'(rd_stall), 64'(rq && empty_e && !rnb));
        check("R7", "rd_fail", 64'(rd_fail), 64'(rq && empty_e && rnb));
        if (rdone) begin
            check("R1", "rd_data", 64'(rd_data), 64'(q[0][DW-1:0]));
            check("R2", "rd_ctrl", 64'(rd_ctrl), 64'(q[0][DW]));
            check("R9", "rd_tag_err", 64'(rd_tag_err), 64'(rnb && (q[0][DW] != rexp)));
        end else begin
            check("R9", "rd_tag_err idle", 64'(rd_tag_err), 64'(0));
        end
        ovf_exp = wq && full_e && wnb;
        @(posedge clk);
        if (rdone) void'(q.pop_front());
        if (wdone) q.push_back({wc, wd});
        @(negedge clk);
        check("R11", "fill_level", 64'(fill_level), 64'(q.size()));
        check("R6", "wr_overflow", 64'(wr_overflow), 64'(ovf_exp));
        wr_req = 0; rd_req = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_req = 0; rd_req = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        q.delete();
        #1;
        check("R10", "fill_level after reset", 64'(fill_level), 64'(0));
        check("R10", "rd_exists after reset", 64'(rd_exists), 64'(0));
        check("R10", "wr_full after reset", 64'(wr_full), 64'(0));
        check("R10", "wr_overflow after reset", 64'(wr_overflow), 64'(0));
        @(negedge clk);
    endtask

    // Fill to full, then blocked and non-blocking writes on full (R3, R5, R6).
    task automatic t_fill_full();
        for (int i = 0; i < DEP; i++) step(1, 32'hA000_0000 + 32'(i * 7), 1'(i % 3 == 0), 0, 0, 0, 0);
        step(1, 32'hDEAD_0001, 1, 0, 0, 0, 0);
        step(1, 32'hDEAD_0002, 0, 1, 0, 0, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        check("R3", "fill stays at DEPTH", 64'(fill_level), 64'(DEP));
        check("R6", "overflow one cycle only", 64'(wr_overflow), 64'(0));
    endtask

    // Drain with blocking reads; order and tags against the model (R1, R2).
    task automatic t_drain();
        while (q.size() > 0) step(0, '0, 0, 0, 1, 0, 0);
        check("R4", "empty after drain", 64'(rd_exists), 64'(0));
    endtask

    // Reads on empty: blocking stall, non-blocking fail (R4, R7).
    task automatic t_empty_reads();
        step(0, '0, 0, 0, 1, 0, 0);
        step(0, '0, 0, 0, 1, 1, 1);
        check("R4", "still empty", 64'(fill_level), 64'(0));
    endtask

    // Concurrent read and write, including on a full FIFO (R8).
    task automatic t_concurrent();
        for (int i = 0; i < 3; i++) step(1, 32'h5500 + 32'(i), 1'(i[0]), 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            step(1, 32'h6600 + 32'(i), 1'(i % 2), 1, 1, 0, 0);
            check("R8", "level unchanged", 64'(fill_level), 64'(3));
        end
        while (q.size() < DEP) step(1, 32'h7700 + 32'(q.size()), 0, 0, 0, 0, 0);
        step(1, 32'hBAD0_BAD0, 1, 0, 1, 0, 0);
        t_drain();
    endtask

    // Non-blocking tag checks, word consumed on mismatch (R9).
    task automatic t_tag_mismatch();
        step(1, 32'h1111_0001, 1, 0, 0, 0, 0);
        step(1, 32'h1111_0002, 0, 0, 0, 0, 0);
        step(1, 32'h1111_0003, 0, 0, 0, 0, 0);
        step(0, '0, 0, 0, 1, 1, 0);
        check("R9", "mismatch consumed", 64'(fill_level), 64'(2));
        step(0, '0, 0, 0, 1, 1, 0);
        step(0, '0, 0, 0, 1, 1, 1);
        check("R9", "all consumed", 64'(fill_level), 64'(0));
    endtask

    // Reset mid-stream empties the FIFO (R10).
    task automatic t_reset_mid();
        for (int i = 0; i < 5; i++) step(1, 32'h9900 + 32'(i), 1, 0, 0, 0, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        while (q.size() < DEP) step(1, 32'h9A00 + 32'(q.size()), 0, 0, 0, 0, 0);
        step(1, 32'hFFFF_FFFF, 0, 1, 0, 0, 0);
        t_reset();
        step(0, '0, 0, 0, 1, 1, 0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_full();
        t_drain();
        t_empty_reads();
        t_concurrent();
        t_tag_mismatch();
        t_reset_mid();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule